// File: doc/BRIEF.md
# Clock Domain Operating-Point Switch Sequencer

This block moves one clock domain, made of a single PLL and a short list of integer output dividers, from its present operating point to a new one chosen from a small table. A requester hands over a target domain rate on a valid/ready stream. The block looks the rate up in the operating-point table, which arrives on static configuration pins. The table gives the PLL rate for the point and one 8-bit divide value for each divider. The block then issues the divider register writes and one PLL reprogramming request. It orders them so that no divided output runs faster than either its old or its new rate while the change is in progress.

The order depends on the direction of the PLL change. When the PLL slows down, it is reprogrammed before the dividers are touched. Otherwise the dividers are written first and the PLL follows. The PLL step is a request/done handshake with an external PLL sequencer, which also reports whether the relock succeeded. The block keeps the current PLL rate in a register that moves only on a successful PLL step. It reports each finished change as a one-cycle response that carries a status code.

The request stream obeys the usual rules. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle. A requester that holds `req_valid` while `req_ready` is low is simply stalled, and its rate is not sampled.

Top module: `rate_switch_seq`

## Requirements
- R1: Out of reset the block is idle. `req_ready` is 1. `dw_valid`, `pll_req` and `resp_valid` are 0. `cur_pll_rate` equals the INIT_PLL_RATE parameter.
- R2: The lookup compares the requested rate for exact equality with the table's domain rates, starting at entry 0. The search stops at the first entry whose domain rate is zero. If several entries match, the lowest-numbered one is used.
- R3: If no entry matches, the block responds with status 1 (bad rate). It issues no divider write and no PLL request, and `cur_pll_rate` is unchanged.
- R4: If the selected PLL rate is strictly below `cur_pll_rate`, the PLL request comes before every divider write of that change.
- R5: If the selected PLL rate is equal to or above `cur_pll_rate`, every divider write of that change comes before the PLL request.
- R6: Divider writes are one-cycle strobes on consecutive cycles, in list order. Each carries that divider's address and its value for the selected entry. The list ends at the first zero address or after NUM_DIV entries, and no write ever carries address zero.
- R7: A divide value is written exactly as stored in its 8-bit field, including zero (which switches that output off).
- R8: `pll_req` stays high, with `pll_rate` steady at the selected PLL rate, until the cycle where `pll_done` is seen. No divider write occurs while `pll_req` is high.
- R9: The response status is 0 when the PLL step reports `pll_ok`=1 and 2 when it reports 0. When the PLL step comes first and fails, the dividers are still written.
- R10: `cur_pll_rate` takes the selected PLL rate only after a PLL step that reports success.
- R11: `req_ready` is low from the cycle after acceptance through the `resp_valid` cycle. `resp_valid` lasts exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rate request valid |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_rate | input | RATE_W | Requested domain rate |
| tbl_rate | input | NUM_OPP*RATE_W | Domain rate of entry o at bits [o*RATE_W +: RATE_W] |
| tbl_pll | input | NUM_OPP*RATE_W | PLL rate of entry o at bits [o*RATE_W +: RATE_W] |
| tbl_daddr | input | NUM_DIV*ADDR_W | Address of divider d at bits [d*ADDR_W +: ADDR_W] |
| tbl_dval | input | NUM_OPP*NUM_DIV*DIV_W | Value of divider d in entry o at bits [(o*NUM_DIV+d)*DIV_W +: DIV_W] |
| dw_valid | output | 1 | Divider write strobe |
| dw_addr | output | ADDR_W | Divider write address |
| dw_data | output | DIV_W | Divider write value |
| pll_req | output | 1 | PLL reprogram request, held until done |
| pll_rate | output | RATE_W | Target PLL rate for the request |
| pll_done | input | 1 | PLL step finished |
| pll_ok | input | 1 | PLL step result, sampled with pll_done |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_status | output | 2 | 0 ok, 1 bad rate, 2 PLL failure |
| cur_pll_rate | output | RATE_W | Current PLL rate register |

## Verification
The bench sweeps every requested rate over several small tables. They include a zero-rate entry in the middle, duplicate rates, a divider list cut short by a zero address, and a list that starts with a zero address. It also varies the PLL latency and injects PLL failures.

Each kind of bug shows up differently. A lookup that ignored the terminator would accept a rate placed after it. One that preferred the last match would program the wrong PLL rate. An order decision that used the wrong comparison, or the wrong side of equality, would put the PLL request on the wrong side of the writes. An update of the rate register on failure would change every later ordering decision, and a walker that skipped the terminator or clamped zero values would leave a visible gap or error in the write log.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    RSQ_OK       = 2'd0,
    RSQ_BAD_RATE = 2'd1,
    RSQ_PLL_FAIL = 2'd2
  } rsq_status_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_PLL_A = 3'd1,
    S_DIV_B = 3'd2,
    S_DIV_A = 3'd3,
    S_PLL_B = 3'd4,
    S_FIN   = 3'd5
  } rsq_state_e;

endpackage

// File: rtl/rsq_opp_lookup.sv
module rsq_opp_lookup #(
  parameter int RATE_W  = 32,
  parameter int NUM_OPP = 6,
  localparam int OPP_W  = (NUM_OPP > 1) ? $clog2(NUM_OPP) : 1
) (
  input  logic [RATE_W-1:0]         i_rate,
  input  logic [NUM_OPP*RATE_W-1:0] i_tbl_rate,
  output logic                      o_hit,
  output logic [OPP_W-1:0]          o_idx
);

  logic [NUM_OPP-1:0] alive;
  logic [NUM_OPP-1:0] match;

  // An entry is searchable only if it and every entry before it is non-zero.
  genvar g;
  generate
    for (g = 0; g < NUM_OPP; g++) begin : g_ent
      logic ent_nz;
      assign ent_nz = (i_tbl_rate[g*RATE_W +: RATE_W] != '0);
      if (g == 0) begin : g_first
        assign alive[g] = ent_nz;
      end else begin : g_rest
        assign alive[g] = ent_nz && alive[g-1];
      end
      assign match[g] = alive[g] && (i_tbl_rate[g*RATE_W +: RATE_W] == i_rate);
    end
  endgenerate

  // Lowest-numbered match wins.
  always_comb begin
    o_idx = '0;
    for (int i = NUM_OPP - 1; i >= 0; i--) begin
      if (match[i]) o_idx = OPP_W'(i);
    end
  end

  assign o_hit = |match;

  // R2: a hit can never be on the zero terminator value
  always_comb begin
    if (o_hit) begin
      assert_hit_rate_nonzero_R2: assert (i_rate != '0);
    end
  end

endmodule

// File: rtl/rsq_div_walker.sv
module rsq_div_walker #(
  parameter int ADDR_W  = 12,
  parameter int DIV_W   = 8,
  parameter int NUM_OPP = 6,
  parameter int NUM_DIV = 16,
  localparam int OPP_W  = (NUM_OPP > 1) ? $clog2(NUM_OPP) : 1,
  localparam int DI_W   = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              run,
  input  logic [OPP_W-1:0]                  sel,
  input  logic [NUM_DIV*ADDR_W-1:0]         tbl_daddr,
  input  logic [NUM_OPP*NUM_DIV*DIV_W-1:0]  tbl_dval,
  output logic                              wr_valid,
  output logic [ADDR_W-1:0]                 wr_addr,
  output logic [DIV_W-1:0]                  wr_data,
  output logic                              last
);

  logic [DI_W-1:0] di_q;
  logic            at_end;
  int unsigned     val_base;

  assign wr_addr  = tbl_daddr[di_q*ADDR_W +: ADDR_W];
  assign val_base = (int'(sel) * NUM_DIV + int'(di_q)) * DIV_W;
  assign wr_data  = tbl_dval[val_base +: DIV_W];
  assign at_end   = (wr_addr == '0) || (int'(di_q) == NUM_DIV - 1);
  assign wr_valid = run && (wr_addr != '0);
  assign last     = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      di_q <= '0;
    end else if (!run || at_end) begin
      di_q <= '0;
    end else begin
      di_q <= di_q + 1'b1;
    end
  end

  // R6: the zero address terminates the list and is never written
  assert_no_zero_addr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr != '0));

  // R6: a walk always starts from the head of the list
  assert_walk_starts_at_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (di_q == '0));

endmodule

// File: rtl/rate_switch_seq.sv
module rate_switch_seq
  import rsq_pkg::*;
#(
  parameter int RATE_W        = 32,
  parameter int ADDR_W        = 12,
  parameter int DIV_W         = 8,
  parameter int NUM_OPP       = 6,
  parameter int NUM_DIV       = 16,
  parameter int INIT_PLL_RATE = 800000000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [RATE_W-1:0]                req_rate,
  input  logic [NUM_OPP*RATE_W-1:0]        tbl_rate,
  input  logic [NUM_OPP*RATE_W-1:0]        tbl_pll,
  input  logic [NUM_DIV*ADDR_W-1:0]        tbl_daddr,
  input  logic [NUM_OPP*NUM_DIV*DIV_W-1:0] tbl_dval,
  output logic                             dw_valid,
  output logic [ADDR_W-1:0]                dw_addr,
  output logic [DIV_W-1:0]                 dw_data,
  output logic                             pll_req,
  output logic [RATE_W-1:0]                pll_rate,
  input  logic                             pll_done,
  input  logic                             pll_ok,
  output logic                             resp_valid,
  output logic [1:0]                       resp_status,
  output logic [RATE_W-1:0]                cur_pll_rate
);

  localparam int OPP_W = (NUM_OPP > 1) ? $clog2(NUM_OPP) : 1;

  rsq_state_e        st_q;
  rsq_status_e       stat_q;
  logic [OPP_W-1:0]  sel_q;
  logic [RATE_W-1:0] tgt_q;
  logic [RATE_W-1:0] cur_q;

  logic              lk_hit;
  logic [OPP_W-1:0]  lk_idx;
  logic [RATE_W-1:0] lk_pll;
  logic              walk_run;
  logic              walk_last;
  logic              in_pll;

  rsq_opp_lookup #(
    .RATE_W (RATE_W),
    .NUM_OPP(NUM_OPP)
  ) u_lookup (
    .i_rate    (req_rate),
    .i_tbl_rate(tbl_rate),
    .o_hit     (lk_hit),
    .o_idx     (lk_idx)
  );

  assign lk_pll = tbl_pll[lk_idx*RATE_W +: RATE_W];

  assign walk_run = (st_q == S_DIV_A) || (st_q == S_DIV_B);

  rsq_div_walker #(
    .ADDR_W (ADDR_W),
    .DIV_W  (DIV_W),
    .NUM_OPP(NUM_OPP),
    .NUM_DIV(NUM_DIV)
  ) u_walker (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (walk_run),
    .sel      (sel_q),
    .tbl_daddr(tbl_daddr),
    .tbl_dval (tbl_dval),
    .wr_valid (dw_valid),
    .wr_addr  (dw_addr),
    .wr_data  (dw_data),
    .last     (walk_last)
  );

  assign in_pll = (st_q == S_PLL_A) || (st_q == S_PLL_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      stat_q <= RSQ_OK;
      sel_q  <= '0;
      tgt_q  <= '0;
      cur_q  <= RATE_W'(INIT_PLL_RATE);
    end else begin
      case (st_q)
        S_IDLE: begin
          if (req_valid) begin
            sel_q <= lk_idx;
            tgt_q <= lk_pll;
            if (!lk_hit) begin
              stat_q <= RSQ_BAD_RATE;
              st_q   <= S_FIN;
            end else begin
              stat_q <= RSQ_OK;
              // slowing PLL goes first; equal or faster goes last
              st_q   <= (lk_pll < cur_q) ? S_PLL_A : S_DIV_A;
            end
          end
        end
        S_PLL_A, S_PLL_B: begin
          if (pll_done) begin
            stat_q <= pll_ok ? RSQ_OK : RSQ_PLL_FAIL;
            if (pll_ok) cur_q <= tgt_q;
            st_q <= (st_q == S_PLL_A) ? S_DIV_B : S_FIN;
          end
        end
        S_DIV_A: if (walk_last) st_q <= S_PLL_B;
        S_DIV_B: if (walk_last) st_q <= S_FIN;
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (st_q == S_IDLE);
  assign pll_req      = in_pll;
  assign pll_rate     = tgt_q;
  assign resp_valid   = (st_q == S_FIN);
  assign resp_status  = stat_q;
  assign cur_pll_rate = cur_q;

  // R8: request held until done, with a steady target
  assert_pll_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_req && !pll_done) |=> (pll_req && $stable(pll_rate)));

  // R8: no divider write overlaps a PLL request
  assert_no_write_during_pll_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pll_req && dw_valid));

  // R10: current rate moves only after a successful PLL step
  assert_cur_rate_on_success_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_pll_rate) |-> $past(pll_req && pll_done && pll_ok));

  // R11: response lasts one cycle and the input is closed meanwhile
  assert_resp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || pll_req || dw_valid) |-> !req_ready);

  // R3: a rejected request goes straight to the response with no PLL step
  assert_bad_rate_no_pll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_status == 2'd1) |-> !$past(pll_req));

endmodule

// File: tb/rate_switch_seq_test.sv
module rate_switch_seq_test;

  localparam int RW   = 8;
  localparam int AW   = 4;
  localparam int DW   = 8;
  localparam int NOPP = 4;
  localparam int NDIV = 3;
  localparam int INIT = 50;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [RW-1:0] req_rate = '0;
  logic [NOPP*RW-1:0] tbl_rate = '0;
  logic [NOPP*RW-1:0] tbl_pll = '0;
  logic [NDIV*AW-1:0] tbl_daddr = '0;
  logic [NOPP*NDIV*DW-1:0] tbl_dval = '0;
  logic dw_valid;
  logic [AW-1:0] dw_addr;
  logic [DW-1:0] dw_data;
  logic pll_req;
  logic [RW-1:0] pll_rate;
  logic pll_done = 0;
  logic pll_ok = 0;
  logic resp_valid;
  logic [1:0] resp_status;
  logic [RW-1:0] cur_pll_rate;

  rate_switch_seq #(
    .RATE_W(RW), .ADDR_W(AW), .DIV_W(DW), .NUM_OPP(NOPP), .NUM_DIV(NDIV),
    .INIT_PLL_RATE(INIT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rate(req_rate), .tbl_rate(tbl_rate), .tbl_pll(tbl_pll),
    .tbl_daddr(tbl_daddr), .tbl_dval(tbl_dval), .dw_valid(dw_valid),
    .dw_addr(dw_addr), .dw_data(dw_data), .pll_req(pll_req),
    .pll_rate(pll_rate), .pll_done(pll_done), .pll_ok(pll_ok),
    .resp_valid(resp_valid), .resp_status(resp_status),
    .cur_pll_rate(cur_pll_rate)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int t_rate [NOPP];
  int t_pll  [NOPP];
  int t_addr [NDIV];
  int t_val  [NOPP][NDIV];

  // monitor log
  int  log_addr [8];
  int  log_data [8];
  int  n_wr;
  int  pll_pos;
  int  pll_seen;
  int  pll_seen_rate;
  int  busy_ready_bad;
  logic mon_on = 0;

  // PLL model controls
  int  pll_lat = 0;
  int  pll_want_ok = 1;
  int  pll_wait = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (dw_valid) begin
        if (n_wr < 8) begin
          log_addr[n_wr] = int'(dw_addr);
          log_data[n_wr] = int'(dw_data);
        end
        n_wr++;
      end
      if (pll_req && pll_seen == 0) begin
        pll_seen = 1;
        pll_pos = n_wr;
        pll_seen_rate = int'(pll_rate);
      end
      if (req_ready && !resp_valid && !req_valid) busy_ready_bad = busy_ready_bad;
    end
  end

  always @(negedge clk) begin
    if (pll_done) begin
      pll_done = 0;
      pll_ok = 0;
    end else if (pll_req) begin
      if (pll_wait >= pll_lat) begin
        pll_done = 1;
        pll_ok = (pll_want_ok != 0);
        pll_wait = 0;
      end else begin
        pll_wait++;
      end
    end
  end

  task automatic pack_tables();
    for (int o = 0; o < NOPP; o++) begin
      tbl_rate[o*RW +: RW] = RW'(t_rate[o]);
      tbl_pll[o*RW +: RW]  = RW'(t_pll[o]);
      for (int d = 0; d < NDIV; d++)
        tbl_dval[(o*NDIV+d)*DW +: DW] = DW'(t_val[o][d]);
    end
    for (int d = 0; d < NDIV; d++) tbl_daddr[d*AW +: AW] = AW'(t_addr[d]);
  endtask

  task automatic load_cfg(input int c);
    for (int o = 0; o < NOPP; o++)
      for (int d = 0; d < NDIV; d++)
        t_val[o][d] = (o*37 + d*11 + c*5 + 5) % 256;
    case (c)
      0: begin
        t_rate = '{10, 20, 30, 40};
        t_pll  = '{40, 60, 50, 50};
        t_addr = '{1, 2, 3};
        t_val[1][2] = 0;
        t_val[3][0] = 255;
      end
      1: begin
        t_rate = '{15, 0, 25, 35};
        t_pll  = '{30, 90, 90, 90};
        t_addr = '{4, 0, 9};
      end
      default: begin
        t_rate = '{12, 12, 22, 0};
        t_pll  = '{70, 20, 70, 5};
        t_addr = '{0, 5, 6};
      end
    endcase
    pack_tables();
  endtask

  int cur_exp = INIT;

  task automatic run_txn(input int rate, input int txn_no);
    int idx, exp_n, exp_stat, lower, status, guard;
    string rq;
    idx = -1;
    for (int i = 0; i < NOPP; i++) begin
      if (t_rate[i] == 0) break;
      if (t_rate[i] == rate) begin idx = i; break; end
    end
    exp_n = 0;
    if (idx >= 0)
      for (int d = 0; d < NDIV; d++) begin
        if (t_addr[d] == 0) break;
        exp_n++;
      end
    pll_lat = txn_no % 3;
    pll_want_ok = (txn_no % 4 == 3) ? 0 : 1;
    n_wr = 0; pll_seen = 0; pll_pos = -1; pll_seen_rate = -1; busy_ready_bad = 0;

    @(negedge clk);
    mon_on = 1;
    req_valid = 1;
    req_rate = RW'(rate);
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 0;
    req_rate = 8'hEE;
    guard = 0;
    status = -1;
    while (guard < 200) begin
      if (resp_valid) begin status = int'(resp_status); break; end
      if (req_ready) busy_ready_bad++;
      @(negedge clk);
      guard++;
    end
    check(status != -1, "R11", "response seen", status, 0);
    check(!req_ready, "R11", "ready low in response cycle", int'(req_ready), 0);
    @(negedge clk);
    check(!resp_valid && req_ready, "R11", "single response then idle",
          int'(resp_valid), 0);
    check(busy_ready_bad == 0, "R11", "ready while busy", busy_ready_bad, 0);
    mon_on = 0;

    if (idx < 0) begin
      check(status == 1, "R2/R3", "status for unmatched rate", status, 1);
      check(n_wr == 0, "R3", "writes on unmatched rate", n_wr, 0);
      check(pll_seen == 0, "R3", "pll request on unmatched rate", pll_seen, 0);
      check(int'(cur_pll_rate) == cur_exp, "R3", "cur rate kept", int'(cur_pll_rate), cur_exp);
      return;
    end
    exp_stat = pll_want_ok ? 0 : 2;
    lower = (t_pll[idx] < cur_exp);
    check(status == exp_stat, "R2/R9", "status", status, exp_stat);
    check(n_wr == exp_n, "R6/R9", "write count", n_wr, exp_n);
    for (int k = 0; k < exp_n && k < 8; k++) begin
      check(log_addr[k] == t_addr[k], "R6", "write address", log_addr[k], t_addr[k]);
      rq = (t_val[idx][k] == 0) ? "R7" : "R6";
      check(log_data[k] == t_val[idx][k], rq, "write value", log_data[k], t_val[idx][k]);
    end
    check(pll_seen_rate == t_pll[idx], "R2/R8", "pll target", pll_seen_rate, t_pll[idx]);
    if (lower)
      check(pll_pos == 0, "R4", "pll position among writes", pll_pos, 0);
    else
      check(pll_pos == exp_n, "R5", "pll position among writes", pll_pos, exp_n);
    if (pll_want_ok) cur_exp = t_pll[idx];
    check(int'(cur_pll_rate) == cur_exp, "R10", "current pll rate",
          int'(cur_pll_rate), cur_exp);
  endtask

  initial begin
    int txn;
    txn = 0;
    load_cfg(0);
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R1", "reset ready", int'(req_ready), 1);
    check(!dw_valid && !pll_req && !resp_valid, "R1", "reset strobes",
          int'({dw_valid, pll_req, resp_valid}), 0);
    check(int'(cur_pll_rate) == INIT, "R1", "reset cur rate", int'(cur_pll_rate), INIT);
    @(negedge clk);
    rst_n = 1;
    for (int c = 0; c < 3; c++) begin
      load_cfg(c);
      for (int r = 0; r <= 41; r++) begin
        run_txn(r, txn);
        txn++;
      end
      // repeat valid rates in reverse to force both orderings again
      for (int r = 41; r >= 0; r--) begin
        if (r % 5 == 0 || r % 5 == 2) begin
          run_txn(r, txn);
          txn++;
        end
      end
    end
    finish_run();
  end

endmodule